// File: doc/BRIEF.md
# Backplane Master Requester with Cycle Timeout

This block sits on a processor card between the local CPU and a shared multi-master backplane. It watches the CPU's cycles. When one is aimed at the backplane address window, it asks the arbiter for the bus without any software action. When the grant arrives it claims ownership, opens the buffers that connect the CPU to the backplane, runs that single transaction and then lets the bus go.

Software can also set a hold bit. The block then requests the bus and keeps it across any number of transfers, which suits block moves that must not be split. Ownership lasts until software clears the bit, and while the bit is set a release request from the arbiter is ignored and only recorded. Two watchdogs protect the CPU. One ends a cycle with a bus error if the grant does not come in time. The other does the same if the target never acknowledges the data. Software can then retry.

Top module: `bus_master_req`

## Requirements
- R1: A CPU strobe whose address has its top `WIN_BITS` bits equal to `WIN_TAG` (default: bits 23..20 equal to 0xE) raises `bp_req` one cycle later. A strobe outside the window never raises it.
- R2: When `bp_grant` is seen while requesting, the next cycle shows `bp_busy` high and `bp_req` low. `bp_req` and `bp_busy` are never high together.
- R3: `bp_drive_en` is high only while the bus is owned and a CPU cycle is in flight. `bp_addr` equals `cpu_addr` while `bp_drive_en` is high and is zero otherwise.
- R4: `bp_dtack` during a driven cycle gives a one-cycle `cpu_ack` pulse on the next cycle. In transparent mode, `bp_busy` falls on the cycle after that pulse.
- R5: Writing 1 to the hold bit (`hold_wr_en` with `hold_wr_val`) makes the block request the bus with no CPU cycle pending. It keeps `bp_busy` high across several transfers until a 0 is written, and releases the bus on the cycle after the hold bit reads 0.
- R6: `stat[0]` reads the hold bit and `stat[1]` reads current ownership, equal to `bp_busy`.
- R7: If a backplane cycle has waited `GRANT_LIMIT` cycles (default 256) without a grant, the block gives a one-cycle `cpu_err` pulse and drops `bp_req`.
- R8: If a driven cycle sees no `bp_dtack` for `ACK_LIMIT` cycles (default 64), the block gives a one-cycle `cpu_err` pulse. In transparent mode ownership is then released.
- R9: While the hold bit is set and the bus is owned, `bp_clear` does not end ownership. It sets the sticky flag `stat[2]`, and writing 0 to the hold bit clears that flag.
- R10: In transparent mode, a `bp_clear` during a transfer does not cut it short. The cycle completes normally and the bus is released after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_strobe | input | 1 | CPU cycle valid, held until ack or error |
| cpu_addr | input | AW | CPU address |
| cpu_ack | output | 1 | One-cycle cycle-complete pulse |
| cpu_err | output | 1 | One-cycle bus-error pulse |
| bp_req | output | 1 | Bus request to arbiter |
| bp_grant | input | 1 | Bus grant from arbiter |
| bp_busy | output | 1 | Bus ownership indication |
| bp_clear | input | 1 | Arbiter request to release the bus |
| bp_dtack | input | 1 | Data acknowledge from target |
| bp_drive_en | output | 1 | Enable for backplane buffers |
| bp_addr | output | AW | Address presented through the buffers |
| hold_wr_en | input | 1 | Hold-bit write strobe |
| hold_wr_val | input | 1 | Value written to the hold bit |
| stat | output | 3 | {clear seen, owned, hold} |

## Verification
The hardest situation to reach is a release request that arrives while the hold bit keeps the bus across back-to-back transfers. The arbiter must have granted, a first transfer must have finished, and `bp_clear` must rise before the software release. The bench's arbiter and target models react to the outputs each cycle. This lets the stimulus set the hold bit, complete two transfers, pulse the clear line between them and only then write 0. The two timeouts are reached by turning off the grant or acknowledge responders for longer than the default limits.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_GNT, S_OWN, S_XFER, S_DONE, S_GNT_ERR, S_ACK_ERR
  } bmr_state_e;

  // true on the last permitted cycle of a wait that started with count 0
  function automatic logic wait_expired(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  function automatic logic state_owns(input bmr_state_e s);
    return (s == S_OWN) || (s == S_XFER) || (s == S_DONE) || (s == S_ACK_ERR);
  endfunction
endpackage

// File: rtl/bmr_decode.sv
module bmr_decode #(
  parameter int TAG_BITS = 4,
  parameter logic [TAG_BITS-1:0] TAG = 'hE
) (
  input  logic                cyc_i,
  input  logic [TAG_BITS-1:0] tag_i,
  output logic                hit_o
);
  assign hit_o = cyc_i && (tag_i == TAG);
endmodule

// File: rtl/bmr_timer.sv
module bmr_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (cnt != '1)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bmr_ctl.sv
module bmr_ctl
  import bmr_pkg::*;
#(
  parameter int GRANT_LIMIT = 256,
  parameter int ACK_LIMIT   = 64,
  parameter int CW          = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          hold,
  input  logic          grant,
  input  logic          dtack,
  input  logic [CW-1:0] cnt,
  output logic          restart,
  output bmr_state_e    st
);
  bmr_state_e st_nxt;
  logic grant_late, ack_late;

  assign grant_late = wait_expired(32'(cnt), GRANT_LIMIT);
  assign ack_late   = wait_expired(32'(cnt), ACK_LIMIT);

  always_comb begin
    st_nxt = st;
    unique case (st)
      S_IDLE:     if (hit || hold) st_nxt = S_WAIT_GNT;
      S_WAIT_GNT: if (grant)                 st_nxt = hit ? S_XFER : S_OWN;
                  else if (!(hit || hold))   st_nxt = S_IDLE;
                  else if (hit && grant_late) st_nxt = S_GNT_ERR;
      S_OWN:      if (hit) st_nxt = S_XFER;
                  else if (!hold) st_nxt = S_IDLE;
      S_XFER:     if (dtack) st_nxt = S_DONE;
                  else if (ack_late) st_nxt = S_ACK_ERR;
      S_DONE, S_ACK_ERR: st_nxt = hold ? S_OWN : S_IDLE;
      S_GNT_ERR:  st_nxt = S_IDLE;
      default:    st_nxt = S_IDLE;
    endcase
  end

  assign restart = (st_nxt != st);

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/bus_master_req.sv
module bus_master_req
  import bmr_pkg::*;
#(
  parameter int AW          = 24,
  parameter int WIN_BITS    = 4,
  parameter logic [WIN_BITS-1:0] WIN_TAG = 'hE,
  parameter int GRANT_LIMIT = 256,
  parameter int ACK_LIMIT   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_strobe,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_ack,
  output logic          cpu_err,
  output logic          bp_req,
  input  logic          bp_grant,
  output logic          bp_busy,
  input  logic          bp_clear,
  input  logic          bp_dtack,
  output logic          bp_drive_en,
  output logic [AW-1:0] bp_addr,
  input  logic          hold_wr_en,
  input  logic          hold_wr_val,
  output logic [2:0]    stat
);
  localparam int MAXL = (GRANT_LIMIT > ACK_LIMIT) ? GRANT_LIMIT : ACK_LIMIT;
  localparam int CW   = $clog2(MAXL) + 1;

  logic          win_hit;
  logic          hold_q;
  logic          clr_seen_q;
  logic          tmr_restart;
  logic [CW-1:0] tmr_cnt;
  bmr_state_e    st;
  logic          owned;

  bmr_decode #(.TAG_BITS(WIN_BITS), .TAG(WIN_TAG)) u_dec (
    .cyc_i (cpu_strobe),
    .tag_i (cpu_addr[AW-1 -: WIN_BITS]),
    .hit_o (win_hit)
  );

  bmr_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .cnt     (tmr_cnt)
  );

  bmr_ctl #(.GRANT_LIMIT(GRANT_LIMIT), .ACK_LIMIT(ACK_LIMIT), .CW(CW)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (win_hit),
    .hold    (hold_q),
    .grant   (bp_grant),
    .dtack   (bp_dtack),
    .cnt     (tmr_cnt),
    .restart (tmr_restart),
    .st      (st)
  );

  assign owned = state_owns(st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      clr_seen_q <= 1'b0;
    end else begin
      if (hold_wr_en) hold_q <= hold_wr_val;
      if (hold_wr_en && !hold_wr_val)           clr_seen_q <= 1'b0;
      else if (bp_clear && hold_q && owned)     clr_seen_q <= 1'b1;
    end
  end

  assign bp_req      = (st == S_WAIT_GNT);
  assign bp_busy     = owned;
  assign bp_drive_en = (st == S_XFER);
  assign bp_addr     = bp_drive_en ? cpu_addr : '0;
  assign cpu_ack     = (st == S_DONE);
  assign cpu_err     = (st == S_GNT_ERR) || (st == S_ACK_ERR);
  assign stat        = {clr_seen_q, owned, hold_q};
endmodule

// File: rtl/bus_master_req_chk.sv
module bus_master_req_chk (
  input logic clk,
  input logic rst_n,
  input logic bp_req,
  input logic bp_grant,
  input logic bp_busy,
  input logic bp_dtack,
  input logic bp_drive_en,
  input logic cpu_ack,
  input logic cpu_err,
  input logic hold_q,
  input logic hold_wr_en
);
  AST_REQ_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp_req && bp_busy)); // R2
  AST_GRANT_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req && bp_grant |=> bp_busy && !bp_req); // R2
  AST_DRIVE_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    bp_drive_en |-> bp_busy); // R3
  AST_DTACK_GIVES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bp_drive_en && bp_dtack |=> cpu_ack); // R4
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack); // R4
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |=> !cpu_err); // R7
  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ack && cpu_err)); // R8
  AST_HOLD_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bp_busy && hold_q && !hold_wr_en |=> bp_busy); // R9
endmodule

bind bus_master_req bus_master_req_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bp_req      (bp_req),
  .bp_grant    (bp_grant),
  .bp_busy     (bp_busy),
  .bp_dtack    (bp_dtack),
  .bp_drive_en (bp_drive_en),
  .cpu_ack     (cpu_ack),
  .cpu_err     (cpu_err),
  .hold_q      (hold_q),
  .hold_wr_en  (hold_wr_en)
);

// File: tb/test_bus_master_req.sv
module test_bus_master_req;
  localparam int GL = 256;
  localparam int AL = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_strobe = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic bp_grant = 1'b0, bp_clear = 1'b0, bp_dtack = 1'b0;
  logic hold_wr_en = 1'b0, hold_wr_val = 1'b0;
  logic cpu_ack, cpu_err, bp_req, bp_busy, bp_drive_en;
  logic [23:0] bp_addr;
  logic [2:0] stat;

  always #10 clk = ~clk;

  bus_master_req i_bus_master_req (
    .clk(clk), .rst_n(rst_n), .cpu_strobe(cpu_strobe), .cpu_addr(cpu_addr),
    .cpu_ack(cpu_ack), .cpu_err(cpu_err), .bp_req(bp_req), .bp_grant(bp_grant),
    .bp_busy(bp_busy), .bp_clear(bp_clear), .bp_dtack(bp_dtack),
    .bp_drive_en(bp_drive_en), .bp_addr(bp_addr), .hold_wr_en(hold_wr_en),
    .hold_wr_val(hold_wr_val), .stat(stat)
  );

  int checks = 0, fails = 0;

  // ---------------- behavioural reference model ----------------
  // phase: 0 free, 1 asking, 2 holding idle, 3 transfer, 4 completed,
  //        5 grant timeout, 6 ack timeout
  int phase = 0, waited = 0;
  bit m_hold = 0, m_clr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; waited = 0; m_hold = 0; m_clr = 0;
    end else begin
      automatic bit in_win = cpu_strobe && (cpu_addr[23:20] == 4'hE);
      automatic bit owns = (phase == 2) || (phase == 3) || (phase == 4) || (phase == 6);
      automatic int nxt = phase;
      if (phase == 0) begin
        if (in_win || m_hold) nxt = 1;
      end else if (phase == 1) begin
        if (bp_grant) nxt = in_win ? 3 : 2;
        else if (!in_win && !m_hold) nxt = 0;
        else if (in_win && waited >= GL - 1) nxt = 5;
      end else if (phase == 2) begin
        if (in_win) nxt = 3; else if (!m_hold) nxt = 0;
      end else if (phase == 3) begin
        if (bp_dtack) nxt = 4; else if (waited >= AL - 1) nxt = 6;
      end else if (phase == 5) nxt = 0;
      else nxt = m_hold ? 2 : 0;
      waited = (nxt != phase) ? 0 : waited + 1;
      if (hold_wr_en && !hold_wr_val) m_clr = 0;
      else if (bp_clear && m_hold && owns) m_clr = 1;
      if (hold_wr_en) m_hold = hold_wr_val;
      phase = nxt;
    end
  end

  task automatic cmp1(input string tag, input string nm, input logic [23:0] act, input logic [23:0] exp, inout bit ok);
    if (act !== exp) begin
      ok = 0;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    automatic bit ok = 1;
    automatic bit owns = (phase == 2) || (phase == 3) || (phase == 4) || (phase == 6);
    cmp1("R1", "bp_req", 24'(bp_req), 24'(phase == 1), ok);
    cmp1("R2", "bp_busy", 24'(bp_busy), 24'(owns), ok);
    cmp1("R3", "bp_drive_en", 24'(bp_drive_en), 24'(phase == 3), ok);
    cmp1("R3", "bp_addr", bp_addr, (phase == 3) ? cpu_addr : 24'h0, ok);
    cmp1("R4", "cpu_ack", 24'(cpu_ack), 24'(phase == 4), ok);
    cmp1("R7 R8", "cpu_err", 24'(cpu_err), 24'((phase == 5) || (phase == 6)), ok);
    cmp1("R5 R6 R9", "stat", 24'(stat), 24'({m_clr, owns, m_hold}), ok);
    checks++;
    if (!ok) fails++;
  endtask

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // responders
  bit gnt_on = 1, ack_on = 1;
  int gnt_delay = 2, ack_delay = 1, req_seen = 0, drv_seen = 0;
  int n_ack = 0, n_err = 0, busy_drops = 0;
  bit last_busy = 0;

  task automatic tick();
    @(negedge clk);
    compare_all();
    if (cpu_ack) n_ack++;
    if (cpu_err) n_err++;
    if (last_busy && !bp_busy) busy_drops++;
    last_busy = bp_busy;
    req_seen = bp_req ? req_seen + 1 : 0;
    drv_seen = bp_drive_en ? drv_seen + 1 : 0;
    bp_grant = gnt_on && bp_req && (req_seen > gnt_delay);
    bp_dtack = ack_on && bp_drive_en && (drv_seen > ack_delay);
    if (cpu_ack || cpu_err) cpu_strobe = 0;
    hold_wr_en = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic cpu_cycle(input logic [23:0] a);
    cpu_addr = a; cpu_strobe = 1;
    for (int i = 0; i < 400 && cpu_strobe; i++) tick();
  endtask

  task automatic write_hold(input bit v);
    hold_wr_en = 1; hold_wr_val = v;
    @(negedge clk); // the write lands at the intervening edge
    compare_all();
    hold_wr_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bp_req === 0 && bp_busy === 0 && cpu_ack === 0 && cpu_err === 0 && stat === 0,
          "reset R2 R6", int'(stat), 0);
    rst_n = 1;
    run(2);

    // R1: out-of-window cycle never requests
    cpu_addr = 24'h3F_0000; cpu_strobe = 1;
    run(6);
    check(bp_req === 0, "R1 outside window", int'(bp_req), 0);
    cpu_strobe = 0; run(2);

    // R1 R2 R3 R4: transparent cycle
    n_ack = 0; busy_drops = 0;
    cpu_cycle(24'hE1_2345);
    run(3);
    check(n_ack == 1, "R4 one ack", n_ack, 1);
    check(busy_drops == 1 && bp_busy === 0, "R4 released", busy_drops, 1);

    // different delays
    gnt_delay = 0; ack_delay = 4; n_ack = 0;
    cpu_cycle(24'hEF_FFFF);
    cpu_cycle(24'hE0_0000);
    run(2);
    check(n_ack == 2, "R4 back to back", n_ack, 2);

    // R7: grant never comes
    gnt_on = 0; n_err = 0;
    cpu_cycle(24'hE0_0010);
    run(2);
    check(n_err == 1 && bp_req === 0, "R7 grant timeout", n_err, 1);
    gnt_on = 1;

    // R8: acknowledge never comes
    ack_on = 0; n_err = 0; busy_drops = 0;
    cpu_cycle(24'hE0_0020);
    run(2);
    check(n_err == 1, "R8 ack timeout", n_err, 1);
    check(bp_busy === 0 && busy_drops == 1, "R8 released", busy_drops, 1);
    ack_on = 1;

    // R10: clear during a transparent transfer
    ack_delay = 3; n_ack = 0;
    cpu_addr = 24'hE5_5555; cpu_strobe = 1;
    run(3); bp_clear = 1;
    for (int i = 0; i < 50 && cpu_strobe; i++) tick();
    bp_clear = 0; run(2);
    check(n_ack == 1 && bp_busy === 0, "R10 cycle completed then released", n_ack, 1);

    // R5 R6 R9: hold across transfers with clear in between
    gnt_delay = 2; ack_delay = 1; busy_drops = 0; n_ack = 0;
    write_hold(1);
    run(6);
    check(bp_busy === 1 && stat[1] === 1 && stat[0] === 1, "R5 R6 held without cycle", int'(stat), 3);
    cpu_cycle(24'hE0_0100);
    bp_clear = 1; run(3); bp_clear = 0;
    check(stat[2] === 1 && bp_busy === 1, "R9 clear ignored and flagged", int'(stat), 7);
    cpu_cycle(24'hE0_0104);
    run(3);
    check(busy_drops == 0 && n_ack == 2, "R5 kept across transfers", busy_drops, 0);
    write_hold(0);
    run(3);
    check(bp_busy === 0 && stat === 3'b000, "R5 R9 released and flag cleared", int'(stat), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule